// File: doc/BRIEF.md
# Flow Control Packet Checker

This block screens link-level packets arriving on a byte stream. The only legal link packet is the six-byte flow control packet. It carries an opcode, a virtual lane number, a running total of blocks sent and a credit limit, and it is protected by a 16-bit CRC. Bytes arrive one per cycle when the valid strobe is high. A start marker opens a packet and an end marker closes it. Idle cycles may appear between the bytes of a packet.

When the end byte is taken, the block judges the whole packet in a single step. A packet that passes every check produces a one-cycle update pulse that carries the parsed credit fields, together with a one-hot select for the addressed lane. A packet that fails is dropped and gives a one-cycle error pulse with a single cause code. When several checks fail at once, the cause reported is the one with the highest precedence. A separate mask input states which lanes are supported.

Top module: `lpc_flow_check`

## Requirements
- R1: After a synchronous active-high reset, and on every cycle without a verdict, `upd_valid`, `err_valid`, `lane_sel` and `err_code` are all zero.
- R2: The wire layout is fixed. The high nibble of byte 0 is the opcode and its low nibble is the lane. Byte 1 and the high nibble of byte 2 hold the 12-bit blocks-sent value, MSB first. The low nibble of byte 2 and byte 3 hold the 12-bit credit limit. Bytes 4 and 5 are the CRC, high byte first. A clean packet raises `upd_valid` for exactly one cycle, in the cycle after its end byte is taken, with those fields on the `upd_*` outputs.
- R3: A packet whose accepted byte count from start to end is not 6 is reported with `err_code` 1 (length).
- R4: The CRC uses polynomial 0x100B, initial value 0xFFFF, MSB-first bit order, no reflection and no final inversion, and covers bytes 0 to 3. A mismatch with bytes 4 and 5 is reported with `err_code` 2.
- R5: Opcode 0 is a normal update (`upd_init` = 0) and opcode 1 is an initialization update (`upd_init` = 1). Any other opcode is reported with `err_code` 3.
- R6: A lane number of `NUM_VL` or more, or one whose bit in `lane_enable` is clear, is reported with `err_code` 4.
- R7: When several checks fail, the code reported is the first failing check in the order length, CRC, opcode, lane.
- R8: A packet that fails any check produces no update pulse and no lane select.
- R9: Bytes with `in_valid` low, and valid bytes outside an open packet that carry no start marker, are ignored. A start marker inside an open packet drops the partial packet silently and begins a new one.
- R10: During an update, `lane_sel` is one-hot at the position of `upd_vl`.
- R11: Each accepted end byte produces exactly one of `upd_valid` and `err_valid`, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | 8 | Packet byte |
| lane_enable | input | NUM_VL | Supported-lane mask |
| upd_valid | output | 1 | Clean packet pulse |
| upd_init | output | 1 | Update is an initialization |
| upd_vl | output | 4 | Addressed lane |
| upd_blocks | output | 12 | Blocks-sent total |
| upd_limit | output | 12 | Credit limit |
| lane_sel | output | NUM_VL | One-hot lane select |
| err_valid | output | 1 | Dropped packet pulse |
| err_code | output | 3 | Cause: 1 length, 2 CRC, 3 opcode, 4 lane |

## Verification
The hardest cases to reach are those where several checks fail in one packet, because each lower-precedence failure stays hidden unless every higher check passes or is deliberately broken as well. The bench builds each packet from field values, computes a correct CRC for it, and then damages only the fields a given scenario needs. Examples are a bad opcode under a correct CRC, a bad CRC over a bad opcode, and a seven-byte packet whose first six bytes are otherwise valid. Restarts in the middle of a packet and stray bytes before the start marker are driven through the same task.

// File: rtl/lpc_pkg.sv
package lpc_pkg;

    localparam int FC_BYTES  = 6;
    localparam int HDR_BYTES = 4;
    localparam int CNT_W     = 3;
    localparam logic [15:0] CRC_POLY = 16'h100B;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;

    localparam logic [3:0] OPC_NORMAL = 4'd0;
    localparam logic [3:0] OPC_INIT   = 4'd1;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_LEN  = 3'd1,
        ERR_CRC  = 3'd2,
        ERR_OPC  = 3'd3,
        ERR_LANE = 3'd4
    } err_e;

    typedef struct packed {
        logic [3:0]  opcode;
        logic [3:0]  vl;
        logic [11:0] blocks;
        logic [11:0] limit;
    } fc_hdr_t;

    function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                             input logic [7:0]  byte_in);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ byte_in[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/lpc_framer.sv
module lpc_framer
    import lpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [7:0]       in_data,
    output logic             take,
    output logic             start,
    output logic             done,
    output logic [CNT_W-1:0] count_next,
    output fc_hdr_t          hdr
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic                           open_q;
    logic [CNT_W-1:0]               cnt_q;
    logic [HDR_BYTES-1:0][7:0]      hdr_q;
    logic [CNT_W-1:0]               idx;

    assign start = in_valid && in_sop;
    assign take  = in_valid && (in_sop || open_q);
    assign done  = take && in_eop;
    assign idx   = in_sop ? '0 : cnt_q;

    always_comb begin
        if (in_sop)               count_next = 1;
        else if (cnt_q == CNT_MAX) count_next = CNT_MAX;
        else                      count_next = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            hdr_q  <= '0;
        end else if (take) begin
            open_q <= !in_eop;
            cnt_q  <= count_next;
            case (idx)
                3'd0: hdr_q[3] <= in_data;
                3'd1: hdr_q[2] <= in_data;
                3'd2: hdr_q[1] <= in_data;
                3'd3: hdr_q[0] <= in_data;
                default: ;
            endcase
        end
    end

    assign hdr = fc_hdr_t'(hdr_q);

    // R9: the byte count always restarts at one on a start marker
    p_sop_restart_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sop) |=> (cnt_q == 3'd1));

    // R9: a byte with no strobe leaves the framing state untouched
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(cnt_q) && $stable(open_q)));

endmodule

// File: rtl/lpc_crc16.sv
module lpc_crc16
    import lpc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        take,
    input  logic        start,
    input  logic [7:0]  in_data,
    output logic        residue_zero
);
    logic [15:0] crc_q;
    logic [15:0] crc_next;

    assign crc_next     = crc_step(start ? CRC_SEED : crc_q, in_data);
    assign residue_zero = (crc_next == 16'h0000);

    always_ff @(posedge clk) begin
        if (rst)       crc_q <= CRC_SEED;
        else if (take) crc_q <= crc_next;
    end

    // R4: register only moves on accepted bytes
    p_crc_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(crc_q));

endmodule

// File: rtl/lpc_judge.sv
module lpc_judge
    import lpc_pkg::*;
#(
    parameter int NUM_VL = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [CNT_W-1:0]  count_next,
    input  logic              crc_ok,
    input  fc_hdr_t           hdr,
    input  logic [NUM_VL-1:0] lane_enable,
    output logic              upd_valid,
    output fc_hdr_t           upd_hdr,
    output logic              err_valid,
    output err_e              err_code
);
    logic len_ok, opc_ok, lane_ok;
    err_e verdict;

    assign len_ok = (count_next == 3'(FC_BYTES));
    assign opc_ok = (hdr.opcode == OPC_NORMAL) || (hdr.opcode == OPC_INIT);

    always_comb begin
        lane_ok = 1'b0;
        for (int i = 0; i < NUM_VL; i++)
            if (hdr.vl == 4'(i)) lane_ok = lane_enable[i];
    end

    always_comb begin
        if (!len_ok)       verdict = ERR_LEN;
        else if (!crc_ok)  verdict = ERR_CRC;
        else if (!opc_ok)  verdict = ERR_OPC;
        else if (!lane_ok) verdict = ERR_LANE;
        else               verdict = ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_valid <= 1'b0;
            upd_hdr   <= '0;
            err_valid <= 1'b0;
            err_code  <= ERR_NONE;
        end else begin
            upd_valid <= done && (verdict == ERR_NONE);
            err_valid <= done && (verdict != ERR_NONE);
            err_code  <= done ? verdict : ERR_NONE;
            if (done && verdict == ERR_NONE) upd_hdr <= hdr;
        end
    end

    // R11: each closing byte yields exactly one verdict
    p_one_verdict_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (upd_valid ^ err_valid));

    // R11: no verdict without a closing byte
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (rst)
        !done |=> (!upd_valid && !err_valid));

    // R8: an error pulse always carries a cause
    p_err_coded_r8: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> (err_code != ERR_NONE));

    // R3: a wrong length is never reported as anything else
    p_len_first_r3: assert property (@(posedge clk) disable iff (rst)
        (done && !len_ok) |=> (err_code == ERR_LEN));

endmodule

// File: rtl/lpc_flow_check.sv
module lpc_flow_check
    import lpc_pkg::*;
#(
    parameter int NUM_VL = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [7:0]        in_data,
    input  logic [NUM_VL-1:0] lane_enable,
    output logic              upd_valid,
    output logic              upd_init,
    output logic [3:0]        upd_vl,
    output logic [11:0]       upd_blocks,
    output logic [11:0]       upd_limit,
    output logic [NUM_VL-1:0] lane_sel,
    output logic              err_valid,
    output logic [2:0]        err_code
);
    logic             take, start, done, crc_ok;
    logic [CNT_W-1:0] count_next;
    fc_hdr_t          hdr, upd_hdr;
    err_e             code;

    lpc_framer u_framer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .take(take), .start(start),
        .done(done), .count_next(count_next), .hdr(hdr)
    );

    lpc_crc16 u_crc (
        .clk(clk), .rst(rst), .take(take), .start(start),
        .in_data(in_data), .residue_zero(crc_ok)
    );

    lpc_judge #(.NUM_VL(NUM_VL)) u_judge (
        .clk(clk), .rst(rst), .done(done), .count_next(count_next),
        .crc_ok(crc_ok), .hdr(hdr), .lane_enable(lane_enable),
        .upd_valid(upd_valid), .upd_hdr(upd_hdr),
        .err_valid(err_valid), .err_code(code)
    );

    assign upd_init   = upd_valid && (upd_hdr.opcode == OPC_INIT);
    assign upd_vl     = upd_hdr.vl;
    assign upd_blocks = upd_hdr.blocks;
    assign upd_limit  = upd_hdr.limit;
    assign err_code   = code;

    for (genvar g = 0; g < NUM_VL; g++) begin : g_lane
        assign lane_sel[g] = upd_valid && (upd_hdr.vl == 4'(g));
    end

    // R10: a lane select appears only with an update and names one lane
    p_lane_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> ($countones(lane_sel) == 1));
    // R8: dropped packets select no lane
    p_no_sel_on_err_r8: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |-> (lane_sel == '0));

endmodule

// File: tb/tb_lpc_flow_check.sv
module tb_lpc_flow_check;
    localparam int NUM_VL = 8;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_sop = 0, in_eop = 0;
    logic [7:0] in_data = 0;
    logic [NUM_VL-1:0] lane_enable = 8'hF7;
    logic upd_valid, upd_init, err_valid;
    logic [3:0] upd_vl;
    logic [11:0] upd_blocks, upd_limit;
    logic [NUM_VL-1:0] lane_sel;
    logic [2:0] err_code;

    int n_run = 0, n_fail = 0;
    logic [7:0] pkt [0:9];

    lpc_flow_check #(.NUM_VL(NUM_VL)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    function automatic logic [15:0] ref_crc(input logic [31:0] msg);
        logic [15:0] r = 16'hFFFF;
        for (int k = 31; k >= 0; k--) begin
            logic top = r[15] ^ msg[k];
            r = r << 1;
            if (top) r = r ^ 16'h100B;
        end
        return r;
    endfunction

    task automatic build(input logic [3:0] opc, input logic [3:0] vl,
                         input logic [11:0] blk, input logic [11:0] lim);
        logic [31:0] m = {opc, vl, blk, lim};
        logic [15:0] c = ref_crc(m);
        pkt[0] = m[31:24]; pkt[1] = m[23:16]; pkt[2] = m[15:8]; pkt[3] = m[7:0];
        pkt[4] = c[15:8];  pkt[5] = c[7:0];
        pkt[6] = 8'h5A;    pkt[7] = 8'hA5;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input int len, input int gap, input bit with_sop);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = pkt[i];
            in_sop = with_sop && (i == 0); in_eop = (i == len - 1);
            if (gap > 0 && i < len - 1) begin
                @(negedge clk); in_valid = 0; in_sop = 0; in_eop = 0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic expect_upd(input string req, input logic [3:0] vl, input bit init,
                              input logic [11:0] blk, input logic [11:0] lim);
        check({req, " upd_valid"}, upd_valid, 1);
        check({req, " err_valid"}, err_valid, 0);
        check({req, " vl"}, upd_vl, vl);
        check({req, " init"}, upd_init, init);
        check({req, " blocks"}, upd_blocks, blk);
        check({req, " limit"}, upd_limit, lim);
        check({req, " lane_sel R10"}, lane_sel, 32'(1) << vl);
        @(negedge clk);
        check({req, " pulse one cycle R2"}, upd_valid, 0);
    endtask

    task automatic expect_err(input string req, input logic [2:0] code);
        check({req, " err_valid"}, err_valid, 1);
        check({req, " err_code"}, err_code, code);
        check({req, " no update R8"}, upd_valid, 0);
        check({req, " no lane R8"}, lane_sel, 0);
        @(negedge clk);
        check({req, " err pulse one cycle R11"}, err_valid, 0);
    endtask

    task automatic t_reset;
        check("R1 upd_valid", upd_valid, 0);
        check("R1 err_valid", err_valid, 0);
        check("R1 lane_sel", lane_sel, 0);
        check("R1 err_code", err_code, 0);
    endtask

    task automatic t_good;
        build(4'd0, 4'd0, 12'hABC, 12'h123); send(6, 0, 1);
        expect_upd("R2 normal vl0", 4'd0, 0, 12'hABC, 12'h123);
        build(4'd1, 4'd5, 12'h001, 12'hFFF); send(6, 2, 1);
        expect_upd("R5 init vl5 gaps", 4'd5, 1, 12'h001, 12'hFFF);
        build(4'd0, 4'd7, 12'h800, 12'h07E); send(6, 0, 1);
        expect_upd("R6 top lane vl7", 4'd7, 0, 12'h800, 12'h07E);
    endtask

    task automatic t_length;
        build(4'd0, 4'd1, 12'h010, 12'h020); send(5, 0, 1);
        expect_err("R3 five bytes", 3'd1);
        send(7, 0, 1);
        expect_err("R3 seven bytes", 3'd1);
        send(1, 0, 1);
        expect_err("R3 single byte", 3'd1);
    endtask

    task automatic t_crc;
        build(4'd0, 4'd2, 12'h111, 12'h222); pkt[5] = pkt[5] ^ 8'h01; send(6, 0, 1);
        expect_err("R4 crc low byte", 3'd2);
        build(4'd0, 4'd2, 12'h111, 12'h222); pkt[2] = pkt[2] ^ 8'h80; send(6, 0, 1);
        expect_err("R4 payload flip", 3'd2);
    endtask

    task automatic t_opc_lane;
        build(4'd2, 4'd1, 12'h333, 12'h444); send(6, 0, 1);
        expect_err("R5 opcode 2", 3'd3);
        build(4'd15, 4'd1, 12'h333, 12'h444); send(6, 0, 1);
        expect_err("R5 opcode 15", 3'd3);
        build(4'd0, 4'd9, 12'h333, 12'h444); send(6, 0, 1);
        expect_err("R6 lane 9 absent", 3'd4);
        build(4'd0, 4'd3, 12'h333, 12'h444); send(6, 0, 1);
        expect_err("R6 lane 3 disabled", 3'd4);
        lane_enable = 8'hFF;
        send(6, 0, 1);
        expect_upd("R6 lane 3 enabled", 4'd3, 0, 12'h333, 12'h444);
        lane_enable = 8'hF7;
    endtask

    task automatic t_precedence;
        build(4'd9, 4'd12, 12'h0, 12'h0); send(7, 0, 1);
        expect_err("R7 length over crc", 3'd1);
        build(4'd9, 4'd12, 12'h0, 12'h0); pkt[4] = ~pkt[4]; send(6, 0, 1);
        expect_err("R7 crc over opcode", 3'd2);
        build(4'd9, 4'd12, 12'h0, 12'h0); send(6, 0, 1);
        expect_err("R7 opcode over lane", 3'd3);
    endtask

    task automatic t_ignore;
        build(4'd0, 4'd4, 12'h0F0, 12'h00F);
        send(3, 0, 0);
        check("R9 stray bytes no err", err_valid, 0);
        pkt[0] = 8'h77; send(1, 0, 0);
        check("R9 stray eop no err", err_valid, 0);
        check("R9 stray eop no upd", upd_valid, 0);
        build(4'd0, 4'd4, 12'h0F0, 12'h00F); send(6, 0, 1);
        expect_upd("R9 after stray", 4'd4, 0, 12'h0F0, 12'h00F);
        @(negedge clk); in_valid = 1; in_sop = 1; in_eop = 0; in_data = 8'h33;
        @(negedge clk); in_sop = 0; in_data = 8'h44;
        @(negedge clk); in_valid = 0;
        check("R9 partial silent", err_valid | upd_valid, 0);
        build(4'd1, 4'd6, 12'h456, 12'h789); send(6, 0, 1);
        expect_upd("R9 restart", 4'd6, 1, 12'h456, 12'h789);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_good();
        t_length();
        t_crc();
        t_opc_lane();
        t_precedence();
        t_ignore();
        repeat (2) @(negedge clk);
        check("R11 idle quiet", upd_valid | err_valid, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule